// File: doc/BRIEF.md
# SPI Host FIFO and Event Unit

This block sits between a host register bus and a serial shifting engine. It keeps two byte FIFOs, one carrying bytes from the host to the engine and one carrying bytes from the engine to the host. The host reaches both through data registers that accept either a packed 32-bit word or a single byte per access. The engine side is a plain byte stream: it takes outgoing bytes with a valid/ready pair and offers incoming bytes the same way.

An event register combines live occupancy counts for both FIFOs with latched flags. The flags cover not-empty and not-full, threshold crossings, overflow and underrun. Software clears a flag by writing a 1 to its bit. A flag whose condition still holds sets again at once. A mask register chooses which flags drive a single registered interrupt line. A control register holds the two programmable thresholds.

Register select on `host_addr`: 0 control, 1 event, 2 mask, 3 transmit data, 4 receive data. Other addresses read as zero and ignore writes. The control register holds the RX threshold in bits 5:0 and the TX threshold in bits 13:8. Event and mask flag positions are: bit 0 RX underrun, bit 1 TX overflow, bit 2 TX at or below threshold, bit 3 RX above threshold, bit 4 RX overflow, bit 8 TX not full, bit 9 RX not empty. All other bits read as zero.

Top module: `spi_evt_fifo`

## Requirements
- R1: While reset is held and just after it, both counts are zero, every event flag is zero, the mask reads 0 and `irq` is 0. The control register reads 0x0000_0403, which is TX threshold 4 and RX threshold 3.
- R2: A word write to address 3 pushes four bytes, bits 31:24 first. The engine receives the bytes in write order through `eng_tx_byte` and `eng_tx_valid`/`eng_tx_ready`. A byte write pushes bits 7:0.
- R3: A TX write that needs more space than is free is ignored and sets event bit 1. A word needs 4 bytes of space and a byte needs 1. The FIFO contents stay unchanged.
- R4: A word read of address 4 with at least four bytes held pops four bytes. The oldest byte appears in bits 31:24.
- R5: A byte read of address 4 pops one byte. It returns the byte in bits 7:0 and zero in bits 31:8.
- R6: A receive read that finds fewer bytes than it needs returns zero, pops nothing and sets event bit 0. A word read needs 4 bytes and a byte read needs 1.
- R7: Event bits 29:24 read the live RX byte count and bits 21:16 read the live TX byte count.
- R8: Bit 9 latches while the RX FIFO holds data and bit 8 latches while the TX FIFO has space. After a clear, each one sets again on the next cycle while its condition holds.
- R9: Writing 1 to an event flag bit clears it once its condition no longer holds. Writing 0 to a bit leaves it unchanged.
- R10: Bit 3 sets while the RX count exceeds the RX threshold. Bit 2 sets while the TX count is at or below the TX threshold.
- R11: `irq` equals the OR of (flags AND mask) from the previous cycle. Only bits 9, 8 and 4:0 of the mask are writable.
- R12: An engine byte offered while the RX FIFO is full is dropped and sets bit 4. `eng_rx_ready` is low exactly when 32 bytes are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (pops on receive data) |
| host_addr | input | 3 | Register select |
| host_byte | input | 1 | 1 = single-byte data access, 0 = word |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for the selected register, same cycle |
| irq | output | 1 | Registered interrupt |
| eng_tx_valid | output | 1 | TX FIFO has a byte for the engine |
| eng_tx_ready | input | 1 | Engine takes the head TX byte |
| eng_tx_byte | output | 8 | Head TX byte |
| eng_rx_valid | input | 1 | Engine offers a received byte |
| eng_rx_ready | output | 1 | RX FIFO can accept a byte |
| eng_rx_byte | input | 8 | Received byte from the engine |

## Verification
Seeded random word and byte streams pass through the TX path. The engine drains them and each byte is compared in order, which separates a byte-order or pointer-wrap fault from a correct FIFO. Random engine bytes come back through a mix of word and byte reads, so a packing error shows up apart from a count error. Directed cases fill the TX FIFO to exactly 32 and to 29 bytes, read short and empty RX FIFOs, and push into a full RX FIFO. They also clear flags whose condition still holds, which separates sticky set-wins behaviour from a plain register. Threshold and mask cases observe the event word and `irq` a fixed number of cycles later.

// File: rtl/spi_evt_pkg.sv
package spi_evt_pkg;
    localparam int FLAG_W      = 10;
    localparam int EV_UNDR     = 0;
    localparam int EV_TXOVF    = 1;
    localparam int EV_TXTHR    = 2;
    localparam int EV_RXTHR    = 3;
    localparam int EV_RXOVF    = 4;
    localparam int EV_TXNF     = 8;
    localparam int EV_RXNE     = 9;
    localparam logic [FLAG_W-1:0] FLAG_LIVE = 10'h31F;
    localparam logic [5:0] TX_THR_RST = 6'd4;
    localparam logic [5:0] RX_THR_RST = 6'd3;

    typedef enum logic [2:0] {
        SEL_CTRL = 3'd0,
        SEL_EVT  = 3'd1,
        SEL_MASK = 3'd2,
        SEL_TXD  = 3'd3,
        SEL_RXD  = 3'd4
    } reg_sel_e;
endpackage

// File: rtl/sef_byte_fifo.sv
module sef_byte_fifo #(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    push_n,
    input  logic [31:0]   push_data,
    input  logic [2:0]    pop_n,
    output logic [31:0]   head,
    output logic [CW-1:0] count
);
    // DEPTH must be a power of two so pointers wrap naturally.
    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    always_ff @(posedge clk) begin
        for (int i = 0; i < 4; i++) begin
            if (i < int'(push_n)) begin
                mem[wr_ptr + AW'(i)] <= push_data[31-8*i -: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            wr_ptr <= wr_ptr + AW'(push_n);
            rd_ptr <= rd_ptr + AW'(pop_n);
            count  <= count + CW'(push_n) - CW'(pop_n);
        end
    end

    always_comb begin
        for (int i = 0; i < 4; i++) begin
            head[31-8*i -: 8] = mem[rd_ptr + AW'(i)];
        end
    end
endmodule

// File: rtl/sef_event_unit.sv
module sef_event_unit #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    input  logic [W-1:0] en_i,
    output logic [W-1:0] flags_o,
    output logic         irq_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_o <= '0;
            irq_o   <= 1'b0;
        end else begin
            // a set in the same cycle as a clear wins
            flags_o <= (flags_o & ~clr_i) | set_i;
            irq_o   <= |(flags_o & en_i);
        end
    end
endmodule

// File: rtl/spi_evt_fifo.sv
module spi_evt_fifo
    import spi_evt_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic [2:0]  host_addr,
    input  logic        host_byte,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        irq,
    output logic        eng_tx_valid,
    input  logic        eng_tx_ready,
    output logic [7:0]  eng_tx_byte,
    input  logic        eng_rx_valid,
    output logic        eng_rx_ready,
    input  logic [7:0]  eng_rx_byte
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    reg_sel_e          sel;
    logic [5:0]        tx_thr_q, rx_thr_q;
    logic [FLAG_W-1:0] mask_q;
    logic [FLAG_W-1:0] ev_flags, ev_set, ev_clr;
    logic [CW-1:0]     tx_cnt, rx_cnt;
    logic [31:0]       tx_head, rx_head;
    logic [2:0]        need, tx_push_n, tx_pop_n, rx_push_n, rx_pop_n;
    logic              wr_txd, rd_rxd, tx_ok, rx_ok;
    logic [31:0]       evt_word;

    assign sel    = reg_sel_e'(host_addr);
    assign need   = host_byte ? 3'd1 : 3'd4;
    assign wr_txd = host_wr && (sel == SEL_TXD);
    assign rd_rxd = host_rd && (sel == SEL_RXD);
    assign tx_ok  = (32'(FULL_CNT) - 32'(tx_cnt)) >= 32'(need);
    assign rx_ok  = 32'(rx_cnt) >= 32'(need);

    assign eng_tx_valid = tx_cnt != '0;
    assign eng_tx_byte  = tx_head[31:24];
    assign eng_rx_ready = rx_cnt != FULL_CNT;

    assign tx_push_n = (wr_txd && tx_ok) ? need : 3'd0;
    assign tx_pop_n  = (eng_tx_valid && eng_tx_ready) ? 3'd1 : 3'd0;
    assign rx_push_n = (eng_rx_valid && eng_rx_ready) ? 3'd1 : 3'd0;
    assign rx_pop_n  = (rd_rxd && rx_ok) ? need : 3'd0;

    sef_byte_fifo #(.DEPTH(DEPTH)) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_n    (tx_push_n),
        .push_data (host_byte ? {host_wdata[7:0], 24'h0} : host_wdata),
        .pop_n     (tx_pop_n),
        .head      (tx_head),
        .count     (tx_cnt)
    );

    sef_byte_fifo #(.DEPTH(DEPTH)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_n    (rx_push_n),
        .push_data ({eng_rx_byte, 24'h0}),
        .pop_n     (rx_pop_n),
        .head      (rx_head),
        .count     (rx_cnt)
    );

    always_comb begin
        ev_set           = '0;
        ev_set[EV_UNDR]  = rd_rxd && !rx_ok;
        ev_set[EV_TXOVF] = wr_txd && !tx_ok;
        ev_set[EV_TXTHR] = 32'(tx_cnt) <= 32'(tx_thr_q);
        ev_set[EV_RXTHR] = 32'(rx_cnt) > 32'(rx_thr_q);
        ev_set[EV_RXOVF] = eng_rx_valid && !eng_rx_ready;
        ev_set[EV_TXNF]  = tx_cnt != FULL_CNT;
        ev_set[EV_RXNE]  = rx_cnt != '0;
        ev_clr = (host_wr && sel == SEL_EVT) ? host_wdata[FLAG_W-1:0] : '0;
    end

    sef_event_unit #(.W(FLAG_W)) u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (ev_set),
        .clr_i   (ev_clr),
        .en_i    (mask_q),
        .flags_o (ev_flags),
        .irq_o   (irq)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_thr_q <= TX_THR_RST;
            rx_thr_q <= RX_THR_RST;
            mask_q   <= '0;
        end else if (host_wr) begin
            if (sel == SEL_CTRL) begin
                tx_thr_q <= host_wdata[13:8];
                rx_thr_q <= host_wdata[5:0];
            end
            if (sel == SEL_MASK) begin
                mask_q <= host_wdata[FLAG_W-1:0] & FLAG_LIVE;
            end
        end
    end

    always_comb begin
        evt_word                 = '0;
        evt_word[29:24]          = 6'(rx_cnt);
        evt_word[21:16]          = 6'(tx_cnt);
        evt_word[FLAG_W-1:0]     = ev_flags;
        host_rdata = '0;
        case (sel)
            SEL_CTRL: host_rdata = {18'h0, tx_thr_q, 2'b00, rx_thr_q};
            SEL_EVT:  host_rdata = evt_word;
            SEL_MASK: host_rdata = {{(32-FLAG_W){1'b0}}, mask_q};
            SEL_RXD:  host_rdata = !rx_ok ? 32'h0 :
                                   (host_byte ? {24'h0, rx_head[31:24]} : rx_head);
            default:  host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sef_chk.sv
module sef_chk
    import spi_evt_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq,
    input logic [FLAG_W-1:0] ev_flags,
    input logic [FLAG_W-1:0] mask_q,
    input logic [CW-1:0]     tx_cnt,
    input logic [CW-1:0]     rx_cnt,
    input logic              host_wr,
    input logic              host_rd,
    input logic [2:0]        host_addr,
    input logic              host_byte,
    input logic              eng_tx_valid,
    input logic              eng_tx_ready,
    input logic              eng_rx_valid
);
    // R11
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == $past(|(ev_flags & mask_q)));

    // R3
    tx_ovf_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 3'd3 && !host_byte && 32'(tx_cnt) > DEPTH - 4
         && !(eng_tx_valid && eng_tx_ready))
        |=> (tx_cnt == $past(tx_cnt)) && ev_flags[EV_TXOVF]);

    // R6
    rx_undr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == 3'd4 && !host_byte && 32'(rx_cnt) < 4 && !eng_rx_valid)
        |=> (rx_cnt == $past(rx_cnt)) && ev_flags[EV_UNDR]);

    // R8
    rxne_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt != '0) |=> ev_flags[EV_RXNE]);

    // R12
    rx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(rx_cnt) <= DEPTH && 32'(tx_cnt) <= DEPTH);
endmodule

bind spi_evt_fifo sef_chk #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .irq          (irq),
    .ev_flags     (ev_flags),
    .mask_q       (mask_q),
    .tx_cnt       (tx_cnt),
    .rx_cnt       (rx_cnt),
    .host_wr      (host_wr),
    .host_rd      (host_rd),
    .host_addr    (host_addr),
    .host_byte    (host_byte),
    .eng_tx_valid (eng_tx_valid),
    .eng_tx_ready (eng_tx_ready),
    .eng_rx_valid (eng_rx_valid)
);

// File: tb/test_spi_evt_fifo.sv
module test_spi_evt_fifo;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        host_wr = 0, host_rd = 0, host_byte = 0;
    logic [2:0]  host_addr = 0;
    logic [31:0] host_wdata = 0;
    logic [31:0] host_rdata;
    logic        irq, eng_tx_valid, eng_rx_ready;
    logic        eng_tx_ready = 0, eng_rx_valid = 0;
    logic [7:0]  eng_tx_byte, eng_rx_byte = 0;

    int nchk = 0, nfail = 0;
    bit done = 0;
    logic [7:0] txq[$];
    logic [7:0] rxq[$];

    always #2 clk = ~clk;

    spi_evt_fifo i_spi_evt_fifo (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_byte(host_byte), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .irq(irq), .eng_tx_valid(eng_tx_valid),
        .eng_tx_ready(eng_tx_ready), .eng_tx_byte(eng_tx_byte),
        .eng_rx_valid(eng_rx_valid), .eng_rx_ready(eng_rx_ready),
        .eng_rx_byte(eng_rx_byte)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic hw(input logic [2:0] a, input logic [31:0] d, input logic b);
        @(negedge clk);
        host_wr = 1; host_addr = a; host_wdata = d; host_byte = b;
        @(posedge clk); #1;
        host_wr = 0; host_byte = 0;
    endtask

    task automatic hr(input logic [2:0] a, input logic b, output logic [31:0] d);
        @(negedge clk);
        host_rd = 1; host_addr = a; host_byte = b;
        #1 d = host_rdata;
        @(posedge clk); #1;
        host_rd = 0; host_byte = 0;
    endtask

    function automatic logic [31:0] cnt_word(input int rxn, input int txn);
        return {2'b0, 6'(rxn), 2'b0, 6'(txn), 16'h0};
    endfunction

    task automatic tx_word(input logic [31:0] w);
        hw(3'd3, w, 1'b0);
        if (txq.size() <= 28)
            for (int i = 0; i < 4; i++) txq.push_back(w[31-8*i -: 8]);
    endtask

    task automatic tx_byte(input logic [7:0] v);
        hw(3'd3, {24'h0, v}, 1'b1);
        if (txq.size() < 32) txq.push_back(v);
    endtask

    task automatic drain_tx(input string req);
        while (txq.size() > 0) begin
            logic [7:0] e;
            e = txq.pop_front();
            @(negedge clk);
            check(req, {23'h0, eng_tx_valid, eng_tx_byte}, {24'h1, e});
            eng_tx_ready = 1;
            @(posedge clk); #1;
            eng_tx_ready = 0;
        end
    endtask

    task automatic eng_push(input logic [7:0] v);
        @(negedge clk);
        eng_rx_valid = 1; eng_rx_byte = v;
        if (eng_rx_ready) rxq.push_back(v);
        @(posedge clk); #1;
        eng_rx_valid = 0;
    endtask

    task automatic rx_read(input string req, input logic b);
        logic [31:0] d, e;
        int n;
        n = b ? 1 : 4;
        e = 0;
        if (rxq.size() >= n) begin
            if (b) e = {24'h0, rxq.pop_front()};
            else for (int i = 0; i < 4; i++) e[31-8*i -: 8] = rxq.pop_front();
        end
        hr(3'd4, b, d);
        check(req, d, e);
    endtask

    task automatic clear_all;
        while (rxq.size() > 0) rx_read("R5", 1'b1);
        drain_tx("R2");
        hw(3'd1, 32'hFFFF_FFFF, 1'b0);
        idle(2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nfail++; nchk++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int seed;
        seed = 32'h5EED_0042;
        void'($urandom(seed));

        // R1: reset state
        host_addr = 3'd1;
        repeat (3) @(posedge clk);
        #1 check("R1 event in reset", host_rdata, 32'h0);
        check("R1 irq in reset", {31'h0, irq}, 32'h0);
        @(negedge clk) rst_n = 1;
        hr(3'd0, 1'b0, d); check("R1 ctrl", d, 32'h0000_0403);
        hr(3'd2, 1'b0, d); check("R1 mask", d, 32'h0);
        hr(3'd1, 1'b0, d); check("R1 counts", d & 32'h3F3F_0000, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);

        // R2 / R7: directed word order and counts
        tx_word(32'hA1B2_C3D4);
        tx_byte(8'h5E);
        hr(3'd1, 1'b0, d); check("R7 tx count", d & 32'h3F3F_0000, cnt_word(0, 5));
        drain_tx("R2 order");

        // R2: random TX streams
        for (int r = 0; r < 20; r++) begin
            int nw;
            nw = 1 + ($urandom % 7);
            for (int k = 0; k < nw; k++) tx_word($urandom);
            if ($urandom % 2) tx_byte(8'($urandom));
            drain_tx("R2 random");
        end

        // R3: exactly full, then ignored word and byte writes
        clear_all();
        for (int k = 0; k < 8; k++) tx_word($urandom);
        tx_word(32'hDEAD_BEEF);
        tx_byte(8'h77);
        hr(3'd1, 1'b0, d); check("R3 count stays 32", d & 32'h3F3F_0000, cnt_word(0, 32));
        idle(1);
        hr(3'd1, 1'b0, d); check("R3 overflow flag", (d >> 1) & 1, 32'h1);
        // R8 / R9: not-full flag clears while full
        hw(3'd1, 32'h0000_0100, 1'b0);
        idle(2);
        hr(3'd1, 1'b0, d); check("R9 txnf cleared when full", (d >> 8) & 1, 32'h0);
        drain_tx("R3 contents");
        // R3: 29 bytes held, word needs 4
        for (int k = 0; k < 7; k++) tx_word($urandom);
        tx_byte(8'hC4);
        tx_word(32'h1234_5678);
        hr(3'd1, 1'b0, d); check("R3 29 bytes", d & 32'h3F3F_0000, cnt_word(0, 29));
        drain_tx("R3 partial");

        // R4 / R5: random RX with mixed reads
        clear_all();
        for (int r = 0; r < 30; r++) begin
            int nb;
            nb = 1 + ($urandom % 9);
            for (int k = 0; k < nb; k++) eng_push(8'($urandom));
            while (rxq.size() > 0) begin
                if (rxq.size() >= 4 && ($urandom % 3 != 0)) rx_read("R4 word", 1'b0);
                else rx_read("R5 byte", 1'b1);
            end
        end

        // R6: underrun on empty and short reads
        clear_all();
        rx_read("R6 empty word", 1'b0);
        idle(1);
        hr(3'd1, 1'b0, d); check("R6 underrun flag", d & 1, 32'h1);
        hw(3'd1, 32'h0000_0001, 1'b0);
        idle(2);
        hr(3'd1, 1'b0, d); check("R9 underrun cleared", d & 1, 32'h0);
        eng_push(8'h11); eng_push(8'h22);
        rx_read("R6 short word", 1'b0);
        hr(3'd1, 1'b0, d); check("R6 nothing popped", d & 32'h3F3F_0000, cnt_word(2, 0));
        // R8: not-empty re-asserts after clear; write of 0 has no effect
        hw(3'd1, 32'h0000_0200, 1'b0);
        idle(2);
        hr(3'd1, 1'b0, d); check("R8 rxne reasserts", (d >> 9) & 1, 32'h1);
        hw(3'd1, 32'h0, 1'b0);
        idle(1);
        hr(3'd1, 1'b0, d); check("R9 zero write keeps underrun", d & 1, 32'h1);
        rx_read("R5 byte", 1'b1);
        rx_read("R5 byte", 1'b1);
        rx_read("R6 empty byte", 1'b1);

        // R12: push into full RX
        clear_all();
        for (int k = 0; k < 33; k++) eng_push(8'($urandom));
        hr(3'd1, 1'b0, d); check("R12 count 32", d & 32'h3F3F_0000, cnt_word(32, 0));
        check("R12 ready low", {31'h0, eng_rx_ready}, 32'h0);
        idle(1);
        hr(3'd1, 1'b0, d); check("R12 rx overflow flag", (d >> 4) & 1, 32'h1);

        // R10: thresholds
        clear_all();
        hw(3'd0, 32'h0000_0003, 1'b0);
        hw(3'd1, 32'hFFFF_FFFF, 1'b0);
        for (int k = 0; k < 3; k++) eng_push(8'($urandom));
        idle(2);
        hr(3'd1, 1'b0, d); check("R10 rx at threshold", (d >> 3) & 1, 32'h0);
        eng_push(8'h99);
        idle(2);
        hr(3'd1, 1'b0, d); check("R10 rx above threshold", (d >> 3) & 1, 32'h1);
        tx_word($urandom);
        hw(3'd1, 32'h0000_0004, 1'b0);
        idle(2);
        hr(3'd1, 1'b0, d); check("R10 tx above threshold", (d >> 2) & 1, 32'h0);
        drain_tx("R10 drain");
        idle(2);
        hr(3'd1, 1'b0, d); check("R10 tx at or below threshold", (d >> 2) & 1, 32'h1);

        // R11: mask and irq
        hw(3'd2, 32'hFFFF_FFFF, 1'b0);
        hr(3'd2, 1'b0, d); check("R11 mask writable bits", d, 32'h0000_031F);
        hw(3'd2, 32'h0000_0200, 1'b0);
        idle(2);
        check("R11 irq on rxne", {31'h0, irq}, 32'h1);
        hw(3'd2, 32'h0, 1'b0);
        idle(1);
        check("R11 irq off when masked", {31'h0, irq}, 32'h0);
        clear_all();
        hw(3'd2, 32'h0000_0001, 1'b0);
        rx_read("R6 empty", 1'b0);
        idle(1);
        check("R11 irq on underrun", {31'h0, irq}, 32'h1);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule